// File: doc/BRIEF.md
# Card Command Issue and Response Capture Engine

This block takes a memory-card command from a host-facing command register and sends it to a card-side command port. The port carries a 6-bit index and a 32-bit argument. The block then waits for the card's reply and sorts the result into one of three outcomes:

- the command went out and no reply was wanted;
- a well-formed reply arrived and was captured;
- the command timed out.

Each outcome is reported on its own flag. A captured reply is kept as four 32-bit response words. The enable bit in the command register clears itself once a command is finished.

The card side uses a simple request/reply handshake. `card_req` stays high for as long as a command is in flight. The card ends the command with a one-cycle `card_resp_valid`, which carries a byte count and a 128-bit payload. The reply's byte 0 is on the top eight bits of the payload. If no reply arrives within `TIMEOUT_CYCLES` cycles of in-flight time, the block closes the command as a timeout.

Top module: `cmdeng_top`

## Requirements
- R1: After reset, `cmd_reg` is 0, all three flags are 0, all response words are 0 and `card_req` is low.
- R2: A command write with enable (bit 10) set and pending (bit 9) clear, made while idle, starts a command. From the next cycle, `card_req` is high, `card_idx` equals write bits 5:0, `card_arg` equals the last value written to the argument register, and all three flags are cleared.
- R3: When response-expected (bit 6) is clear, any reply sets only `flag_sent`, whatever its byte count, and the response words are left unchanged.
- R4: When a response is expected and long (bit 7) is clear, a 4-byte reply sets `flag_resp_end`. Word 0 is then payload bits 127:96 (byte 0 in bits 31:24), and words 1 to 3 become zero.
- R5: When a response is expected, a 16-byte reply sets `flag_resp_end` whether or not bit 7 is set. Word k is then payload bits 127-32k down to 96-32k, except that bit 0 of word 3 is forced to 0.
- R6: When a response is expected, a reply with a byte count of 0, a count other than 4 or 16, or a count of 4 with bit 7 set, sets `flag_timeout` and leaves the response words unchanged.
- R7: If no reply arrives within `TIMEOUT_CYCLES` in-flight cycles, `flag_timeout` is set and `card_req` drops. A reply in the last in-flight cycle still counts as a reply.
- R8: A command finishes on the same clock edge at which its flag is set. At that point `card_req` falls, bit 10 of `cmd_reg` reads 0 and bits 9:0 keep their written values. At most one flag is ever high.
- R9: A write with both enable and pending set stores the command with bit 10 already cleared. It does not raise `card_req` and does not change the flags.
- R10: Any command write made while `card_req` is high is ignored: `cmd_reg`, `card_idx` and the command in progress are not affected.
- R11: A write with enable clear, made while idle, only stores the value in `cmd_reg` and does not start a command.
- R12: Bit 8 (interrupt wait) is stored in `cmd_reg` but otherwise has no effect, so such a command runs like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr | input | 1 | Argument register write strobe |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 11 | Command write data (index 5:0, resp 6, long 7, irq 8, pending 9, enable 10) |
| cmd_reg | output | 11 | Current command register contents |
| card_req | output | 1 | Command in flight towards the card |
| card_idx | output | 6 | Command index to the card |
| card_arg | output | 32 | Command argument to the card |
| card_resp_valid | input | 1 | Card reply strobe, one cycle |
| card_resp_len | input | 5 | Reply byte count (0, 4 or 16 when well formed) |
| card_resp_data | input | 128 | Reply payload, byte 0 in bits 127:120 |
| resp_word0 | output | 32 | Response word 0 |
| resp_word1 | output | 32 | Response word 1 |
| resp_word2 | output | 32 | Response word 2 |
| resp_word3 | output | 32 | Response word 3 |
| flag_sent | output | 1 | Command sent, no reply wanted |
| flag_resp_end | output | 1 | Valid reply captured |
| flag_timeout | output | 1 | Bad or missing reply |

## Verification
The assertions assume three things about the card side:
- `card_resp_valid` is pulsed only while `card_req` is high and lasts a single cycle;
- argument and command writes are not made in the same cycle;
- reset is applied before the first command.

The stimulus drives every input on the falling edge. It raises the reply strobe exactly once per command, after a chosen delay that never goes past the timeout window. When a test needs the timeout, it sends no reply at all. Writes made during a command are placed strictly inside the in-flight window, never on the cycle in which the command completes.

// File: rtl/cmdeng_pkg.sv
package cmdeng_pkg;

    localparam int IDX_W       = 6;
    localparam int WORD_W      = 32;
    localparam int RESP_WORDS  = 4;
    localparam int PAYLOAD_W   = WORD_W * RESP_WORDS;
    localparam int LEN_W       = 5;
    localparam int SHORT_BYTES = WORD_W / 8;
    localparam int LONG_BYTES  = PAYLOAD_W / 8;

    // Field order follows the bit positions of the command register.
    typedef struct packed {
        logic             enable;     // bit 10
        logic             pending;    // bit 9
        logic             irq_wait;   // bit 8
        logic             long_resp;  // bit 7
        logic             want_resp;  // bit 6
        logic [IDX_W-1:0] index;      // bits 5:0
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic timeout;
        logic resp_end;
        logic sent;
    } flags_t;

    typedef enum logic [1:0] {
        OUT_SENT = 2'd0,
        OUT_RESP = 2'd1,
        OUT_TMO  = 2'd2
    } outcome_e;

    function automatic outcome_e classify(input cmd_t c, input logic [LEN_W-1:0] len);
        if (!c.want_resp)
            return OUT_SENT;
        if (len == LEN_W'(LONG_BYTES))
            return OUT_RESP;
        if (len == LEN_W'(SHORT_BYTES) && !c.long_resp)
            return OUT_RESP;
        return OUT_TMO;
    endfunction

    function automatic flags_t outcome_flags(input outcome_e o);
        flags_t f;
        f = '0;
        case (o)
            OUT_SENT: f.sent     = 1'b1;
            OUT_RESP: f.resp_end = 1'b1;
            default:  f.timeout  = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cmdeng_timer.sv
module cmdeng_timer #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

endmodule

// File: rtl/cmdeng_ctrl.sv
module cmdeng_ctrl
    import cmdeng_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     arg_wr,
    input  logic [WORD_W-1:0]        arg_wdata,
    input  logic                     cmd_wr,
    input  cmd_t                     cmd_wdata,
    input  logic                     reply_valid,
    input  logic [LEN_W-1:0]         reply_len,
    input  logic                     expired,
    output cmd_t                     cmd_q,
    output logic [WORD_W-1:0]        arg_launch,
    output logic                     busy,
    output flags_t                   flags,
    output logic                     capture
);
    logic [WORD_W-1:0] arg_q;
    outcome_e          outcome;
    logic              finish;

    assign outcome = classify(cmd_q, reply_len);
    assign finish  = busy && (reply_valid || expired);
    assign capture = busy && reply_valid && (outcome == OUT_RESP);

    always_ff @(posedge clk) begin
        if (rst)
            arg_q <= '0;
        else if (arg_wr)
            arg_q <= arg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            arg_launch <= '0;
            busy       <= 1'b0;
            flags      <= '0;
        end else if (!busy) begin
            if (cmd_wr) begin
                cmd_q <= cmd_wdata;
                if (cmd_wdata.enable) begin
                    if (cmd_wdata.pending) begin
                        cmd_q.enable <= 1'b0;
                    end else begin
                        busy       <= 1'b1;
                        flags      <= '0;
                        arg_launch <= arg_q;
                    end
                end
            end
        end else if (finish) begin
            busy         <= 1'b0;
            cmd_q.enable <= 1'b0;
            flags        <= reply_valid ? outcome_flags(outcome) : outcome_flags(OUT_TMO);
        end
    end

endmodule

// File: rtl/cmdeng_resp_store.sv
module cmdeng_resp_store
    import cmdeng_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             load,
    input  logic                             full,
    input  logic [PAYLOAD_W-1:0]             data,
    output logic [RESP_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar i = 0; i < RESP_WORDS; i++) begin : g_word
        logic [WORD_W-1:0] slice;
        logic [WORD_W-1:0] next_val;

        assign slice = data[PAYLOAD_W-1-WORD_W*i -: WORD_W];

        if (i == 0) begin : g_first
            assign next_val = slice;
        end else if (i == RESP_WORDS - 1) begin : g_last
            assign next_val = full ? {slice[WORD_W-1:1], 1'b0} : '0;
        end else begin : g_mid
            assign next_val = full ? slice : '0;
        end

        always_ff @(posedge clk) begin
            if (rst)
                words[i] <= '0;
            else if (load)
                words[i] <= next_val;
        end
    end

endmodule

// File: rtl/cmdeng_top.sv
module cmdeng_top
    import cmdeng_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arg_wr,
    input  logic [31:0]   arg_wdata,
    input  logic          cmd_wr,
    input  logic [10:0]   cmd_wdata,
    output logic [10:0]   cmd_reg,
    output logic          card_req,
    output logic [5:0]    card_idx,
    output logic [31:0]   card_arg,
    input  logic          card_resp_valid,
    input  logic [4:0]    card_resp_len,
    input  logic [127:0]  card_resp_data,
    output logic [31:0]   resp_word0,
    output logic [31:0]   resp_word1,
    output logic [31:0]   resp_word2,
    output logic [31:0]   resp_word3,
    output logic          flag_sent,
    output logic          flag_resp_end,
    output logic          flag_timeout
);
    cmd_t                              cmd_q;
    flags_t                            flags;
    logic                              busy;
    logic                              expired;
    logic                              capture;
    logic [WORD_W-1:0]                 arg_launch;
    logic [RESP_WORDS-1:0][WORD_W-1:0] words;

    cmdeng_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .expired (expired)
    );

    cmdeng_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .arg_wr      (arg_wr),
        .arg_wdata   (arg_wdata),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cmd_t'(cmd_wdata)),
        .reply_valid (card_resp_valid),
        .reply_len   (card_resp_len),
        .expired     (expired),
        .cmd_q       (cmd_q),
        .arg_launch  (arg_launch),
        .busy        (busy),
        .flags       (flags),
        .capture     (capture)
    );

    cmdeng_resp_store u_store (
        .clk   (clk),
        .rst   (rst),
        .load  (capture),
        .full  (card_resp_len == LEN_W'(LONG_BYTES)),
        .data  (card_resp_data),
        .words (words)
    );

    assign cmd_reg       = cmd_q;
    assign card_req      = busy;
    assign card_idx      = cmd_q.index;
    assign card_arg      = arg_launch;
    assign resp_word0    = words[0];
    assign resp_word1    = words[1];
    assign resp_word2    = words[2];
    assign resp_word3    = words[3];
    assign flag_sent     = flags.sent;
    assign flag_resp_end = flags.resp_end;
    assign flag_timeout  = flags.timeout;

endmodule

// File: rtl/cmdeng_chk.sv
module cmdeng_chk #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cmd_wr,
    input logic [10:0]  cmd_wdata,
    input logic [10:0]  cmd_reg,
    input logic         card_req,
    input logic [5:0]   card_idx,
    input logic         card_resp_valid,
    input logic [4:0]   card_resp_len,
    input logic [31:0]  resp_word1,
    input logic [31:0]  resp_word2,
    input logic [31:0]  resp_word3,
    input logic         flag_sent,
    input logic         flag_resp_end,
    input logic         flag_timeout
);
    localparam int CW = $clog2(TIMEOUT_CYCLES + 2);

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst || !card_req)
            busy_cnt <= '0;
        else
            busy_cnt <= busy_cnt + 1'b1;
    end

    // R8
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_sent, flag_resp_end, flag_timeout}));

    // R8
    req_enable_chk: assert property (@(posedge clk) disable iff (rst)
        card_req |-> cmd_reg[10]);

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (!card_req && cmd_wr && cmd_wdata[10] && !cmd_wdata[9])
        |=> (card_req && card_idx == $past(cmd_wdata[5:0])
             && !flag_sent && !flag_resp_end && !flag_timeout));

    // R9
    pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!card_req && cmd_wr && cmd_wdata[10] && cmd_wdata[9])
        |=> (!card_req && !cmd_reg[10]));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (card_req && !card_resp_valid && cmd_wr && busy_cnt != CW'(TIMEOUT_CYCLES - 1))
        |=> $stable(cmd_reg));

    // R3
    sent_chk: assert property (@(posedge clk) disable iff (rst)
        (card_req && card_resp_valid && !cmd_reg[6])
        |=> (flag_sent && !card_req && !cmd_reg[10]));

    // R4
    short_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (card_req && card_resp_valid && cmd_reg[6] && !cmd_reg[7] && card_resp_len == 5'd4)
        |=> (flag_resp_end && resp_word1 == '0 && resp_word2 == '0 && resp_word3 == '0));

    // R7
    tmo_window_chk: assert property (@(posedge clk) disable iff (rst)
        card_req |-> (busy_cnt < CW'(TIMEOUT_CYCLES)));

endmodule

bind cmdeng_top cmdeng_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmd_wr          (cmd_wr),
    .cmd_wdata       (cmd_wdata),
    .cmd_reg         (cmd_reg),
    .card_req        (card_req),
    .card_idx        (card_idx),
    .card_resp_valid (card_resp_valid),
    .card_resp_len   (card_resp_len),
    .resp_word1      (resp_word1),
    .resp_word2      (resp_word2),
    .resp_word3      (resp_word3),
    .flag_sent       (flag_sent),
    .flag_resp_end   (flag_resp_end),
    .flag_timeout    (flag_timeout)
);

// File: tb/test_cmdeng_top.sv
`timescale 1ns/1ps
module test_cmdeng_top;

    localparam int T = 16;

    typedef struct packed {
        logic [10:0] cmd;
        logic [31:0] arg;
        logic [4:0]  len;
        logic [7:0]  delay;
        logic        reply;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{11'h400, 32'h0000_0000, 5'd0,  8'd2,  1'b1},  // R3 no resp
        '{11'h451, 32'h1234_5678, 5'd4,  8'd0,  1'b1},  // R4 short
        '{11'h4C2, 32'hCAFE_F00C, 5'd16, 8'd5,  1'b1},  // R5 long
        '{11'h4C9, 32'h0000_0001, 5'd4,  8'd1,  1'b1},  // R6 long req, 4 bytes
        '{11'h447, 32'h0F0F_0F0F, 5'd16, 8'd3,  1'b1},  // R5 short req, 16 bytes
        '{11'h443, 32'h0000_0022, 5'd0,  8'd1,  1'b1},  // R6 zero bytes
        '{11'h444, 32'h0000_0033, 5'd8,  8'd2,  1'b1},  // R6 odd length
        '{11'h448, 32'h0000_0044, 5'd4,  8'd0,  1'b0},  // R7 no reply
        '{11'h44A, 32'h8765_4321, 5'd4,  8'd15, 1'b1},  // R7 last-cycle reply
        '{11'h505, 32'h0000_0055, 5'd0,  8'd0,  1'b1},  // R12 irq bit
        '{11'h40B, 32'h0000_0066, 5'd16, 8'd4,  1'b1}   // R3 16 bytes ignored
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         arg_wr;
    logic [31:0]  arg_wdata;
    logic         cmd_wr;
    logic [10:0]  cmd_wdata;
    logic [10:0]  cmd_reg;
    logic         card_req;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic         card_resp_valid;
    logic [4:0]   card_resp_len;
    logic [127:0] card_resp_data;
    logic [31:0]  resp_word0, resp_word1, resp_word2, resp_word3;
    logic         flag_sent, flag_resp_end, flag_timeout;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [31:0] mw [4];
    logic [2:0]  mflags;

    always #10 clk = ~clk;

    cmdeng_top #(.TIMEOUT_CYCLES(T)) i_cmdeng_top (
        .clk(clk), .rst(rst), .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_reg(cmd_reg),
        .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg),
        .card_resp_valid(card_resp_valid), .card_resp_len(card_resp_len),
        .card_resp_data(card_resp_data),
        .resp_word0(resp_word0), .resp_word1(resp_word1),
        .resp_word2(resp_word2), .resp_word3(resp_word3),
        .flag_sent(flag_sent), .flag_resp_end(flag_resp_end), .flag_timeout(flag_timeout)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] mk_data(input logic [31:0] a);
        return {a, ~a, a ^ 32'hA5A5_5A5A, a + 32'd3};
    endfunction

    task automatic chk_words(input string req);
        chk(req, "word0", 128'(resp_word0), 128'(mw[0]));
        chk(req, "word1", 128'(resp_word1), 128'(mw[1]));
        chk(req, "word2", 128'(resp_word2), 128'(mw[2]));
        chk(req, "word3", 128'(resp_word3), 128'(mw[3]));
    endtask

    task automatic chk_flags(input string req);
        chk(req, "flags", 128'({flag_timeout, flag_resp_end, flag_sent}), 128'(mflags));
    endtask

    task automatic write_arg(input logic [31:0] a);
        @(negedge clk); arg_wr = 1'b1; arg_wdata = a;
        @(negedge clk); arg_wr = 1'b0;
    endtask

    task automatic write_cmd(input logic [10:0] c);
        cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic reply(input logic [4:0] len, input logic [31:0] a);
        card_resp_valid = 1'b1; card_resp_len = len; card_resp_data = mk_data(a);
        @(negedge clk); card_resp_valid = 1'b0;
    endtask

    // Expected outcome from the requirements: 0 sent, 1 resp, 2 timeout
    function automatic int exp_outcome(input vec_t v);
        if (!v.reply) return 2;
        if (!v.cmd[6]) return 0;
        if (v.len == 5'd16) return 1;
        if (v.len == 5'd4 && !v.cmd[7]) return 1;
        return 2;
    endfunction

    task automatic run_vec(input vec_t v);
        int o;
        logic [127:0] d;
        o = exp_outcome(v);
        write_arg(v.arg);
        write_cmd(v.cmd);
        chk("R2", "card_req", 128'(card_req), 128'(1'b1));
        chk("R2", "card_idx", 128'(card_idx), 128'(v.cmd[5:0]));
        chk("R2", "card_arg", 128'(card_arg), 128'(v.arg));
        chk("R2", "flags cleared", 128'({flag_timeout, flag_resp_end, flag_sent}), 128'(3'b000));
        if (v.reply) begin
            repeat (v.delay) @(negedge clk);
            chk("R7", "still waiting", 128'(card_req), 128'(1'b1));
            reply(v.len, v.arg);
        end else begin
            repeat (T - 1) @(negedge clk);
            chk("R7", "req before expiry", 128'(card_req), 128'(1'b1));
            @(negedge clk);
        end
        mflags = (o == 0) ? 3'b001 : (o == 1) ? 3'b010 : 3'b100;
        if (o == 1) begin
            d = mk_data(v.arg);
            mw[0] = d[127:96];
            if (v.len == 5'd16) begin
                mw[1] = d[95:64]; mw[2] = d[63:32]; mw[3] = {d[31:1], 1'b0};
            end else begin
                mw[1] = '0; mw[2] = '0; mw[3] = '0;
            end
        end
        chk("R8", "req dropped", 128'(card_req), 128'(1'b0));
        chk("R8", "cmd_reg", 128'(cmd_reg), 128'({1'b0, v.cmd[9:0]}));
        if (o == 0) chk_flags("R3");
        else if (o == 1) chk_flags(v.len == 5'd16 ? "R5" : "R4");
        else chk_flags(v.reply ? "R6" : "R7");
        chk_words(o == 1 ? (v.len == 5'd16 ? "R5" : "R4") : (o == 0 ? "R3" : "R6"));
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) mw[i] = '0;
        mflags = 3'b000;
    endtask

    task automatic chk_reset_state;
        chk("R1", "cmd_reg", 128'(cmd_reg), 128'(11'h0));
        chk("R1", "card_req", 128'(card_req), 128'(1'b0));
        chk_flags("R1");
        chk_words("R1");
    endtask

    initial begin
        rst = 1'b1; arg_wr = 1'b0; arg_wdata = '0; cmd_wr = 1'b0; cmd_wdata = '0;
        card_resp_valid = 1'b0; card_resp_len = '0; card_resp_data = '0;
        do_reset();
        chk_reset_state();

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: pending + enable is stored with enable cleared, nothing issued
        write_cmd(11'h645);
        chk("R9", "cmd_reg", 128'(cmd_reg), 128'(11'h245));
        chk("R9", "card_req", 128'(card_req), 128'(1'b0));
        chk_flags("R9");
        repeat (3) @(negedge clk);
        chk("R9", "card_req later", 128'(card_req), 128'(1'b0));

        // R11: write without enable only stores
        write_cmd(11'h033);
        chk("R11", "cmd_reg", 128'(cmd_reg), 128'(11'h033));
        repeat (3) @(negedge clk);
        chk("R11", "card_req", 128'(card_req), 128'(1'b0));
        chk_flags("R11");

        // R10: command write during flight is ignored
        write_arg(32'hDEAD_BEEF);
        write_cmd(11'h451);
        @(negedge clk);
        write_cmd(11'h47F);
        chk("R10", "cmd_reg", 128'(cmd_reg), 128'(11'h451));
        chk("R10", "card_idx", 128'(card_idx), 128'(6'h11));
        chk("R10", "card_req", 128'(card_req), 128'(1'b1));
        reply(5'd4, 32'hDEAD_BEEF);
        mw[0] = 32'hDEAD_BEEF; mw[1] = '0; mw[2] = '0; mw[3] = '0;
        mflags = 3'b010;
        chk_flags("R10");
        chk_words("R10");
        chk("R10", "cmd_reg after", 128'(cmd_reg), 128'(11'h051));

        // R1: reset in the middle of a command
        write_arg(32'h0000_0077);
        write_cmd(11'h441);
        do_reset();
        chk_reset_state();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule